// File: doc/BRIEF.md
# Double-Buffered Sliced-Text Line Buffer

This block sits between a text slicer and a shared byte-wide output port. Sliced text bytes for the current video line go into one of two equal storage sections. The other section holds the previous complete line, ready to be sent. A line is offered for output only after its end has been signalled. When the port arbiter grants the port, the whole line leaves as a single unbroken burst. Each burst begins with a six-byte header, followed by the stored payload.

The header starts with a four-byte prefix, chosen by a 6-bit identifier. Identifiers below 3Eh give an ancillary-data prefix that ends with the identifier itself. The values 3Eh and 3Fh give a timing-reference code instead. Two bytes follow the prefix: the line number, then the video-standard code. A framing flag rises together with the first header byte and stays high until the video path reports a start-of-active-video code. The flag can therefore cover several text lines in a row. Payload bytes can optionally have the two reserved codes replaced with even-parity values. If a new line arrives while both sections are still occupied, that line is discarded and a sticky overflow indication is raised.

Top module: `text_line_buffer`

## Requirements
- R1: After a synchronous reset, `out_dq`, `out_flag`, `text_req` and `ovf` are all 0.
- R2: `text_req` stays 0 while a line is being written. It becomes 1 one cycle after `line_done` is applied with a nonzero `line_len`, provided the target section was free.
- R3: With `anc_id` below 3Eh, a burst starts with the bytes 00h, FFh, FFh, {2'b00, anc_id}, `line_num`, `std_code`.
- R4: With `anc_id` equal to 3Eh, the burst starts with FFh, 00h, 00h, ABh, `line_num`, `std_code`. With 3Fh, the fourth byte is ECh instead of ABh.
- R5: After the header, exactly `line_len` payload bytes follow, in the order in which they were written.
- R6: Within one burst, `out_dq` stays high on every cycle from the first header byte to the last payload byte.
- R7: With `recode_en` high, a payload 00h is output as 03h and a payload FFh as FCh. With `recode_en` low, both pass unchanged. All other values are never altered.
- R8: `out_flag` rises in the same cycle as the first header byte of a burst. It stays high across later bursts and falls one cycle after `sav_in` is pulsed.
- R9: Whenever `out_dq` is 1, `out_flag` is also 1.
- R10: One line can be written while the previous complete line waits or streams. Completed lines are output in the order in which they were completed.
- R11: A line whose first byte arrives while both sections are occupied is discarded. `ovf` then becomes 1 and stays 1 until reset. Lines written after a section frees up are accepted normally.
- R12: The first header byte appears on `out_data`/`out_dq` after the second rising edge that follows the edge where `text_req` and `grant` were both seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Sliced text byte valid |
| wr_data | input | 8 | Sliced text byte |
| line_done | input | 1 | End-of-line strobe |
| line_len | input | 7 | Byte count of the finished line (1 to 64) |
| line_num | input | 8 | Line number placed in the header |
| std_code | input | 8 | Video-standard code placed in the header |
| anc_id | input | 6 | Header identifier; 3Eh and 3Fh select timing-code framing |
| recode_en | input | 1 | Enables recoding of 00h/FFh payload bytes |
| grant | input | 1 | Port granted by the arbiter |
| sav_in | input | 1 | Pulse when the video path emits a start-of-active-video code |
| text_req | output | 1 | A complete line is waiting for the port |
| out_data | output | 8 | Output byte |
| out_dq | output | 1 | Output byte qualifier |
| out_flag | output | 1 | Sliced-data framing flag |
| ovf | output | 1 | Sticky line-overflow indication |

## Verification
The hardest case to reach is the overflow. It needs both sections occupied at the moment a third line starts, and normal flow never gets there. The stimulus holds `grant` low so that two completed lines pile up, writes a third line that must disappear, then reopens the grant. The scoreboard then confirms that only the first two lines come out, and that a later line is accepted again while `ovf` remains set. The multi-line span of the framing flag is also only visible with back-to-back bursts and no `sav_in` between them. For that reason, `sav_in` is pulsed only after several lines have been drained.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int HDR_LEN = 6;

  typedef enum logic [1:0] {
    SEC_FREE   = 2'd0,
    SEC_FULL   = 2'd1,
    SEC_STREAM = 2'd2
  } sec_state_t;

  // Substitute even-parity values for the two reserved codes.
  function automatic logic [7:0] recode(input logic [7:0] b, input logic en);
    logic [7:0] r;
    r = b;
    if (en && b == 8'h00) r = 8'h03;
    if (en && b == 8'hFF) r = 8'hFC;
    return r;
  endfunction

  // Header byte at position idx (0..5).
  function automatic logic [7:0] hdr_byte(input logic [2:0] idx, input logic [5:0] id,
                                          input logic [7:0] ln, input logic [7:0] sd);
    logic       trc;
    logic [7:0] xy;
    logic [7:0] r;
    trc = (id >= 6'h3E);
    xy  = id[0] ? 8'hEC : 8'hAB;
    case (idx)
      3'd0:    r = trc ? 8'hFF : 8'h00;
      3'd1:    r = trc ? 8'h00 : 8'hFF;
      3'd2:    r = trc ? 8'h00 : 8'hFF;
      3'd3:    r = trc ? xy : {2'b00, id};
      3'd4:    r = ln;
      default: r = sd;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW:0]   waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW:0]   raddr,
  output logic [DW-1:0] rdata
);

  // Two sections, selected by the top address bit.
  logic [DW-1:0] mem [2*DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tlb_fill.sv
module tlb_fill #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          line_done,
  input  logic [LW-1:0] line_len,
  input  logic [7:0]    line_num,
  input  logic [7:0]    std_code,
  input  logic [1:0]    sec_free,
  output logic          mem_we,
  output logic [AW:0]   mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          commit,
  output logic          commit_sel,
  output logic          ovf,
  output logic [LW-1:0] m_len  [2],
  output logic [7:0]    m_line [2],
  output logic [7:0]    m_std  [2]
);

  logic          wsel;
  logic [LW-1:0] wcnt;
  logic          drop;
  logic          tgt_free;
  logic [LW-1:0] len_c;

  assign tgt_free   = sec_free[wsel];
  assign mem_we     = wr_valid && !drop && tgt_free && (wcnt < LW'(DEPTH));
  assign mem_waddr  = {wsel, wcnt[AW-1:0]};
  assign mem_wdata  = wr_data;
  assign len_c      = (line_len > LW'(DEPTH)) ? LW'(DEPTH) : line_len;
  assign commit     = line_done && !drop && tgt_free && (line_len != '0);
  assign commit_sel = wsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel <= 1'b0;
      wcnt <= '0;
      drop <= 1'b0;
      ovf  <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        m_len[i]  <= '0;
        m_line[i] <= '0;
        m_std[i]  <= '0;
      end
    end else if (line_done) begin
      wcnt <= '0;
      drop <= 1'b0;
      if (commit) begin
        m_len[wsel]  <= len_c;
        m_line[wsel] <= line_num;
        m_std[wsel]  <= std_code;
        wsel         <= ~wsel;
      end else if (line_len != '0) begin
        ovf <= 1'b1;
      end
    end else if (wr_valid) begin
      if (!tgt_free) drop <= 1'b1;
      if (wcnt < LW'(DEPTH)) wcnt <= wcnt + LW'(1);
    end
  end

endmodule

// File: rtl/tlb_stream.sv
module tlb_stream
  import tlb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH + HDR_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant,
  input  logic          sav_in,
  input  logic [5:0]    anc_id,
  input  logic          recode_en,
  input  logic [1:0]    sec_full,
  input  logic [LW-1:0] m_len  [2],
  input  logic [7:0]    m_line [2],
  input  logic [7:0]    m_std  [2],
  input  logic [DW-1:0] rdata,
  output logic [AW:0]   raddr,
  output logic          text_req,
  output logic          start,
  output logic          release_sec,
  output logic          cur_sel,
  output logic [DW-1:0] out_data,
  output logic          out_dq,
  output logic          out_flag
);

  logic          busy;
  logic          rsel;
  logic [PW-1:0] pos;
  logic [LW-1:0] cur_len;
  logic [5:0]    c_id;
  logic [7:0]    c_line;
  logic [7:0]    c_std;
  logic          c_rc;
  logic          last;
  logic [PW-1:0] pidx;
  logic          s1_v;
  logic          s1_first;
  logic          s1_pay;
  logic [7:0]    s1_hdr;

  assign text_req    = !busy && sec_full[rsel];
  assign start       = text_req && grant;
  assign last        = busy && (pos == PW'(HDR_LEN) + PW'(cur_len) - PW'(1));
  assign release_sec = last;
  assign cur_sel     = rsel;
  assign pidx        = pos - PW'(HDR_LEN);
  assign raddr       = {rsel, pidx[AW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      rsel     <= 1'b0;
      pos      <= '0;
      cur_len  <= '0;
      c_id     <= '0;
      c_line   <= '0;
      c_std    <= '0;
      c_rc     <= 1'b0;
      s1_v     <= 1'b0;
      s1_first <= 1'b0;
      s1_pay   <= 1'b0;
      s1_hdr   <= '0;
      out_data <= '0;
      out_dq   <= 1'b0;
      out_flag <= 1'b0;
    end else begin
      if (start) begin
        busy    <= 1'b1;
        pos     <= '0;
        cur_len <= m_len[rsel];
        c_line  <= m_line[rsel];
        c_std   <= m_std[rsel];
        c_id    <= anc_id;
        c_rc    <= recode_en;
      end else if (busy) begin
        pos <= pos + PW'(1);
        if (last) begin
          busy <= 1'b0;
          rsel <= ~rsel;
        end
      end
      // stage 1: issue (memory read runs in parallel)
      s1_v     <= busy;
      s1_first <= busy && (pos == '0);
      s1_pay   <= busy && (pos >= PW'(HDR_LEN));
      s1_hdr   <= hdr_byte(pos[2:0], c_id, c_line, c_std);
      // stage 2: registered outputs
      out_dq   <= s1_v;
      out_data <= s1_pay ? recode(rdata, c_rc) : s1_hdr;
      if (s1_v && s1_first) out_flag <= 1'b1;
      else if (sav_in)      out_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/text_line_buffer.sv
module text_line_buffer
  import tlb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          line_done,
  input  logic [LW-1:0] line_len,
  input  logic [7:0]    line_num,
  input  logic [7:0]    std_code,
  input  logic [5:0]    anc_id,
  input  logic          recode_en,
  input  logic          grant,
  input  logic          sav_in,
  output logic          text_req,
  output logic [DW-1:0] out_data,
  output logic          out_dq,
  output logic          out_flag,
  output logic          ovf
);

  logic [1:0]    sec_free;
  logic [1:0]    sec_full;
  sec_state_t    st [2];
  logic          mem_we;
  logic [AW:0]   mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic [AW:0]   mem_raddr;
  logic [DW-1:0] mem_rdata;
  logic          commit;
  logic          commit_sel;
  logic          start;
  logic          release_sec;
  logic          cur_sel;
  logic [LW-1:0] m_len  [2];
  logic [7:0]    m_line [2];
  logic [7:0]    m_std  [2];

  for (genvar s = 0; s < 2; s++) begin : g_sec
    always_ff @(posedge clk) begin
      if (rst)                                   st[s] <= SEC_FREE;
      else if (commit && commit_sel == 1'(s))    st[s] <= SEC_FULL;
      else if (start && cur_sel == 1'(s))        st[s] <= SEC_STREAM;
      else if (release_sec && cur_sel == 1'(s))  st[s] <= SEC_FREE;
    end
    assign sec_free[s] = (st[s] == SEC_FREE);
    assign sec_full[s] = (st[s] == SEC_FULL);
  end

  tlb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  tlb_fill #(.DW(DW), .DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .line_done(line_done), .line_len(line_len), .line_num(line_num),
    .std_code(std_code), .sec_free(sec_free), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .commit(commit),
    .commit_sel(commit_sel), .ovf(ovf), .m_len(m_len), .m_line(m_line),
    .m_std(m_std)
  );

  tlb_stream #(.DW(DW), .DEPTH(DEPTH)) u_stream (
    .clk(clk), .rst(rst), .grant(grant), .sav_in(sav_in), .anc_id(anc_id),
    .recode_en(recode_en), .sec_full(sec_full), .m_len(m_len),
    .m_line(m_line), .m_std(m_std), .rdata(mem_rdata), .raddr(mem_raddr),
    .text_req(text_req), .start(start), .release_sec(release_sec),
    .cur_sel(cur_sel), .out_data(out_data), .out_dq(out_dq),
    .out_flag(out_flag)
  );

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker (
  input logic clk,
  input logic rst,
  input logic grant,
  input logic text_req,
  input logic out_dq,
  input logic out_flag,
  input logic ovf
);

  // R9
  dq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_dq |-> out_flag);

  // R8
  flag_rise_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_flag) |-> out_dq);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R12
  burst_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_dq) |-> ($past(grant, 3) && $past(text_req, 3)));

endmodule

bind text_line_buffer tlb_checker u_chk (
  .clk(clk), .rst(rst), .grant(grant), .text_req(text_req),
  .out_dq(out_dq), .out_flag(out_flag), .ovf(ovf)
);

// File: tb/sim_text_line_buffer.sv
module sim_text_line_buffer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       line_done = 1'b0;
  logic [6:0] line_len = '0;
  logic [7:0] line_num = '0;
  logic [7:0] std_code = '0;
  logic [5:0] anc_id = '0;
  logic       recode_en = 1'b0;
  logic       grant = 1'b0;
  logic       sav_in = 1'b0;
  logic       text_req;
  logic [7:0] out_data;
  logic       out_dq;
  logic       out_flag;
  logic       ovf;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic [8:0] exp_q [$];   // bit 8 marks the first byte of a burst

  always #(CLK_PERIOD/2) clk = ~clk;

  text_line_buffer u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .line_done(line_done), .line_len(line_len), .line_num(line_num),
    .std_code(std_code), .anc_id(anc_id), .recode_en(recode_en),
    .grant(grant), .sav_in(sav_in), .text_req(text_req),
    .out_data(out_data), .out_dq(out_dq), .out_flag(out_flag), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_hdr(input int i, input logic [5:0] id,
                                       input logic [7:0] ln, input logic [7:0] sd);
    bit trc = (id == 6'h3E) || (id == 6'h3F);
    logic [7:0] tr [4];
    logic [7:0] an [4];
    tr = '{8'hFF, 8'h00, 8'h00, (id == 6'h3F) ? 8'hEC : 8'hAB};
    an = '{8'h00, 8'hFF, 8'hFF, {2'b00, id}};
    if (i == 4) return ln;
    if (i == 5) return sd;
    return trc ? tr[i] : an[i];
  endfunction

  function automatic logic [7:0] m_pay(input int i, input logic [7:0] ln);
    if (i == 0) return 8'h00;
    if (i == 1) return 8'hFF;
    return 8'(i * 37) ^ ln;
  endfunction

  function automatic logic [7:0] m_rec(input logic [7:0] b, input logic en);
    if (en && b == 8'h00) return 8'h03;
    if (en && b == 8'hFF) return 8'hFC;
    return b;
  endfunction

  // Driver: writes one line and pushes its expected burst (R3 R4 R5 R7)
  task automatic send_line(input int n, input logic [7:0] ln, input logic [7:0] sd,
                           input bit keep);
    if (keep) begin
      for (int i = 0; i < 6; i++)
        exp_q.push_back({(i == 0), m_hdr(i, anc_id, ln, sd)});
      for (int i = 0; i < n; i++)
        exp_q.push_back({1'b0, m_rec(m_pay(i, ln), recode_en)});
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = m_pay(i, ln);
    end
    @(negedge clk);
    wr_valid  = 1'b0;
    line_done = 1'b1;
    line_len  = 7'(n);
    line_num  = ln;
    std_code  = sd;
    @(negedge clk);
    line_done = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 drain", exp_q.size(), 0);
  endtask

  // Monitor / scoreboard (R5 R6 R9)
  initial begin
    logic prev_dq = 1'b0;
    logic [8:0] e;
    forever begin
      @(negedge clk);
      if (!rst && out_dq) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected byte", out_data, 0);
        end else begin
          e = exp_q.pop_front();
          chk(out_data == e[7:0], "R3/R4/R5/R7 byte", out_data, e[7:0]);
          if (!e[8]) chk(prev_dq, "R6 gap in burst", prev_dq, 1);
          chk(out_flag, "R9 flag with dq", out_flag, 1);
        end
      end
      prev_dq = out_dq;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!out_dq && !out_flag && !text_req && !ovf, "R1 reset",
        {out_dq, out_flag, text_req, ovf}, 0);

    // R2 R3 R7(passthrough) R12: ancillary header, recode off
    anc_id = 6'h15;
    recode_en = 1'b0;
    send_line(5, 8'h21, 8'h07, 1);
    chk(text_req == 1'b1, "R2 req after line_done", text_req, 1);
    grant = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_dq == 1'b0, "R12 not yet", out_dq, 0);
    @(negedge clk);
    chk(out_dq == 1'b1 && out_data == 8'h00, "R12 first byte", out_dq, 1);
    drain();
    chk(out_flag == 1'b1, "R8 flag held", out_flag, 1);

    // R10 R8: ping-pong with grant open, flag spans lines
    send_line(9, 8'h22, 8'h07, 1);
    send_line(3, 8'h23, 8'h07, 1);
    drain();
    chk(out_flag == 1'b1, "R8 flag spans lines", out_flag, 1);
    @(negedge clk) sav_in = 1'b1;
    @(negedge clk) sav_in = 1'b0;
    chk(out_flag == 1'b0, "R8 flag cleared by sav", out_flag, 0);

    // R4 R7: timing-code framing, recode on
    anc_id = 6'h3E;
    recode_en = 1'b1;
    send_line(4, 8'h30, 8'h02, 1);
    drain();
    anc_id = 6'h3F;
    send_line(6, 8'h31, 8'h02, 1);
    drain();

    // R11: overflow with both sections held
    anc_id = 6'h01;
    recode_en = 1'b0;
    grant = 1'b0;
    chk(text_req == 1'b0, "R2 idle req", text_req, 0);
    send_line(4, 8'h40, 8'h05, 1);
    send_line(5, 8'h41, 8'h05, 1);
    chk(ovf == 1'b0, "R11 no ovf yet", ovf, 0);
    send_line(6, 8'h42, 8'h05, 0);
    chk(ovf == 1'b1, "R11 ovf set", ovf, 1);
    chk(text_req == 1'b1, "R10 req held", text_req, 1);
    grant = 1'b1;
    drain();
    send_line(3, 8'h43, 8'h05, 1);
    drain();
    chk(ovf == 1'b1, "R11 ovf sticky", ovf, 1);

    // R5 R6: full-length line
    send_line(64, 8'h50, 8'h09, 1);
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule